// File: doc/BRIEF.md
# Census Disparity Search Engine

This block finds the best stereo match for each left-image pixel. Left and right Census signatures arrive together, one pair per clock. The block keeps a history of recent right-image signatures. For every left signature it scores each stored candidate in parallel: the score is the number of bit positions where the two signatures agree. A registered pairwise comparison tree then selects the candidate with the highest score. The index of that candidate is the disparity.

The search runs from left to right. When a left pixel arrives, every right pixel it could match has already been seen. The history is therefore a plain shift register and needs no look-ahead. A row-start strobe marks the first pixel of each image row. A disparity is only reported once a full set of candidates from the current row is present. Idle cycles, with the valid input low, leave the history unchanged.

Top module: `census_corr`

## Requirements
- R1: After reset, `disp_valid` stays low until a full candidate set has been loaded and has passed through the pipeline.
- R2: Candidate i is the right signature accepted i valid pixels earlier in the same row. Candidate 0 is the right signature presented together with the current left signature.
- R3: Each candidate score is the count of equal bits between the left signature and the candidate, computed as XNOR followed by a ones count. The score ranges from 0 (all bits differ) to SIG_W (identical). The winning score is output on `best_score`.
- R4: `disp` is the index of the candidate with the highest score, in the range 0 to NDISP-1, encoded in log2(NDISP) bits (6 bits by default).
- R5: When several candidates share the highest score, the smallest index wins.
- R6: The result for an input pair appears exactly 1 + log2(NDISP) clock edges after that pair is sampled: one popcount stage plus one edge per comparison level. This is 7 edges by default.
- R7: `disp_valid` is high only for a pixel that has at least NDISP valid right signatures loaded since the last `row_start`, counting its own. The pixel that carries `row_start` counts as the first.
- R8: A cycle with `in_valid` low shifts nothing into the history and produces no valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A left/right signature pair is present |
| row_start | input | 1 | This pair is the first pixel of a row |
| left_sig | input | SIG_W | Left-image Census signature |
| right_sig | input | SIG_W | Right-image Census signature |
| disp_valid | output | 1 | `disp` and `best_score` hold a result |
| disp | output | log2(NDISP) | Winning disparity |
| best_score | output | clog2(SIG_W+1) | Score of the winning candidate |

## Verification
The bench builds the block with its default values: 48-bit signatures and 64 candidates. With these values the full six-level comparison tree is exercised, the two extremes of the score range (0 and 48) can be reached, and disparities 0 and 63 at both ends of the index range are tested. Rows are built so that a chosen pair of history positions holds the same signature as the left input. This drives the tie rule across distant tree branches. Row restarts in the middle of a row and idle bubbles are also covered, which exercises the candidate-count gate at the 64th pixel.

// File: rtl/census_corr.sv
module census_corr #(
  parameter int SIG_W = 48,
  parameter int NDISP = 64,
  localparam int DW = $clog2(NDISP),
  localparam int SW = $clog2(SIG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             row_start,
  input  logic [SIG_W-1:0] left_sig,
  input  logic [SIG_W-1:0] right_sig,
  output logic             disp_valid,
  output logic [DW-1:0]    disp,
  output logic [SW-1:0]    best_score
);
  localparam int HALF = NDISP / 2;

  logic [SIG_W-1:0] sr   [NDISP-1];
  logic [SIG_W-1:0] cand [NDISP];
  logic [SW-1:0]    sc0  [NDISP];
  logic             v0;
  logic [DW-1:0]    fill;
  logic             full;

  logic [SW-1:0]    rsc  [DW][HALF];
  logic [DW-1:0]    rix  [DW][HALF];
  logic [DW-1:0]    rv;

  assign cand[0] = right_sig;
  for (genvar i = 1; i < NDISP; i++) begin : g_cand
    assign cand[i] = sr[i-1];
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sr[0] <= right_sig;
      for (int i = 1; i < NDISP - 1; i++) sr[i] <= sr[i-1];
    end
  end

  assign full = (fill == DW'(NDISP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      v0   <= 1'b0;
    end else begin
      v0 <= in_valid & ~row_start & full;
      if (in_valid) fill <= row_start ? DW'(1) : (full ? fill : fill + DW'(1));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NDISP; i++)
      sc0[i] <= SW'($countones(~(left_sig ^ cand[i])));
  end

  for (genvar t = 0; t < DW; t++) begin : g_tree
    localparam int N = NDISP >> (t + 1);
    if (t == 0) begin : g_leaf
      always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
          if (sc0[2*k+1] > sc0[2*k]) begin
            rsc[0][k] <= sc0[2*k+1];
            rix[0][k] <= DW'(2*k+1);
          end else begin
            rsc[0][k] <= sc0[2*k];
            rix[0][k] <= DW'(2*k);
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rv[0] <= 1'b0;
        else        rv[0] <= v0;
      end
    end else begin : g_node
      always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
          if (rsc[t-1][2*k+1] > rsc[t-1][2*k]) begin
            rsc[t][k] <= rsc[t-1][2*k+1];
            rix[t][k] <= rix[t-1][2*k+1];
          end else begin
            rsc[t][k] <= rsc[t-1][2*k];
            rix[t][k] <= rix[t-1][2*k];
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rv[t] <= 1'b0;
        else        rv[t] <= rv[t-1];
      end
    end
  end

  assign disp_valid = rv[DW-1];
  assign disp       = rix[DW-1][0];
  assign best_score = rsc[DW-1][0];
endmodule

// File: rtl/census_corr_chk.sv
module census_corr_chk #(
  parameter int SIG_W = 48,
  parameter int NDISP = 64,
  localparam int DW  = $clog2(NDISP),
  localparam int SW  = $clog2(SIG_W + 1),
  localparam int LAT = DW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             row_start,
  input logic [SIG_W-1:0] sr_head,
  input logic             disp_valid,
  input logic [SW-1:0]    best_score
);
  logic [LAT-1:0] pipe;
  int unsigned    since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe      <= '0;
      since_rst <= 0;
    end else begin
      pipe <= {pipe[LAT-2:0], in_valid & ~row_start};
      if (since_rst < 32'hFFFF_0000) since_rst <= since_rst + 1;
    end
  end

  a_r6_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> pipe[LAT-1]);

  a_r3_score_bound: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (best_score <= SW'(SIG_W)));

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (since_rst >= NDISP));

  a_r8_hold_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sr_head));
endmodule

bind census_corr census_corr_chk #(.SIG_W(SIG_W), .NDISP(NDISP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_start(row_start),
  .sr_head(sr[0]), .disp_valid(disp_valid), .best_score(best_score)
);

// File: tb/test_census_corr.sv
`timescale 1ns/1ps
module test_census_corr;
  localparam int SIG_W = 48;
  localparam int NDISP = 64;
  localparam int DW = $clog2(NDISP);
  localparam int SW = $clog2(SIG_W + 1);
  localparam int LAT = DW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic row_start = 1'b0;
  logic [SIG_W-1:0] left_sig = '0;
  logic [SIG_W-1:0] right_sig = '0;
  logic disp_valid;
  logic [DW-1:0] disp;
  logic [SW-1:0] best_score;

  census_corr #(.SIG_W(SIG_W), .NDISP(NDISP)) i_census_corr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_start(row_start),
    .left_sig(left_sig), .right_sig(right_sig),
    .disp_valid(disp_valid), .disp(disp), .best_score(best_score)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_tag = "R1";

  logic [SIG_W-1:0] hm [NDISP];
  int mfill = 0;
  logic ev_a [256];
  int   ed_a [256];
  int   es_a [256];
  string tg_a [256];

  function automatic logic [SIG_W-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  task automatic chk_entry(input int idx);
    int j = idx % 256;
    checks++;
    if (disp_valid !== ev_a[j]) begin
      failures++;
      $display("FAIL %s valid cyc=%0d actual=%0b expected=%0b", tg_a[j], idx, disp_valid, ev_a[j]);
    end else if (ev_a[j]) begin
      checks++;
      if (disp !== DW'(ed_a[j]) || best_score !== SW'(es_a[j])) begin
        failures++;
        $display("FAIL %s result cyc=%0d actual=%0d/%0d expected=%0d/%0d",
                 tg_a[j], idx, disp, best_score, ed_a[j], es_a[j]);
      end
    end
  endtask

  task automatic step(input logic v, input logic rs, input logic [SIG_W-1:0] l, input logic [SIG_W-1:0] r);
    int j = cyc % 256;
    int bd = 0;
    int bs = -1;
    @(negedge clk);
    if (cyc >= LAT) chk_entry(cyc - LAT);
    ev_a[j] = 1'b0;
    if (v) begin
      if (rs) mfill = 0;
      for (int i = NDISP - 1; i > 0; i--) hm[i] = hm[i-1];
      hm[0] = r;
      if (mfill < NDISP) mfill++;
      for (int i = 0; i < NDISP; i++) begin
        int s = $countones(~(l ^ hm[i]));
        if (s > bs) begin bs = s; bd = i; end
      end
      ev_a[j] = (mfill == NDISP);
    end
    ed_a[j] = bd;
    es_a[j] = bs;
    tg_a[j] = cur_tag;
    in_valid = v; row_start = rs; left_sig = l; right_sig = r;
    cyc++;
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, rnd(), rnd());
  endtask

  // R1: outputs quiet after reset
  task automatic t_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (disp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset valid actual=%0b expected=0", disp_valid);
    end
  endtask

  // R7 R2 R4: random row, valid from 64th pixel on
  task automatic t_fill_row();
    cur_tag = "R7_fill";
    for (int p = 0; p < 90; p++) step(1'b1, p == 0, rnd(), rnd());
    flush();
  endtask

  // R2 R4 R5 R3: row of 64 where positions d1,d2 (d1<=d2) equal left
  task automatic t_pair(input int d1, input int d2, input string tag);
    logic [SIG_W-1:0] x = rnd();
    cur_tag = tag;
    for (int p = 0; p < NDISP; p++) begin
      logic [SIG_W-1:0] r = rnd();
      if (p == NDISP - 1 - d1 || p == NDISP - 1 - d2) r = x;
      step(1'b1, p == 0, (p == NDISP - 1) ? x : rnd(), r);
    end
    flush();
  endtask

  // R3 R5: constant rights; left equal gives 48, inverted gives 0, both disparity 0
  task automatic t_const(input logic inv);
    logic [SIG_W-1:0] c = rnd();
    cur_tag = inv ? "R3_zero" : "R5_alltie";
    for (int p = 0; p < NDISP + 4; p++) step(1'b1, p == 0, inv ? ~c : c, c);
    flush();
  endtask

  // R8: bubbles between valid pixels do not shift history
  task automatic t_bubbles();
    cur_tag = "R8_bubble";
    for (int p = 0; p < 80; p++) begin
      step(1'b1, p == 0, rnd(), rnd());
      step(1'b0, 1'b0, rnd(), rnd());
      if (p % 3 == 0) step(1'b0, 1'b1, rnd(), rnd());
    end
    flush();
  endtask

  // R7: row_start mid-row restarts the candidate count
  task automatic t_midrow();
    cur_tag = "R7_restart";
    for (int p = 0; p < 40; p++) step(1'b1, p == 0, rnd(), rnd());
    for (int p = 0; p < 70; p++) step(1'b1, p == 0, rnd(), rnd());
    flush();
  endtask

  // R6: back-to-back rows, latency checked cycle by cycle
  task automatic t_rows();
    cur_tag = "R6_stream";
    for (int p = 0; p < 150; p++) step(1'b1, p % 75 == 0, rnd(), rnd());
    flush();
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ev_a[i] = 1'b0; ed_a[i] = 0; es_a[i] = 0; tg_a[i] = "R1"; end
    for (int i = 0; i < NDISP; i++) hm[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_row();
    t_pair(0, 0, "R2_d0");
    t_pair(63, 63, "R4_d63");
    t_pair(17, 17, "R4_d17");
    t_pair(5, 40, "R5_tie");
    t_pair(31, 32, "R5_tie_branch");
    t_const(1'b0);
    t_const(1'b1);
    t_bubbles();
    t_midrow();
    t_rows();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule